// File: doc/BRIEF.md
# Per-Thread Interrupt Pending and Timer Controller

This block keeps the interrupt state for one hardware thread of a processor core. It holds one pending bit for each of eight interrupt sources. Other logic can set or clear any source by its index, or wipe every source at once. The block also runs a 64-bit timebase and a 64-bit countdown timer. When the countdown is already at zero and a tick arrives, it raises the countdown-expiry source instead of interrupting directly.

From the pending bits and three machine-state inputs (external enable, hypervisor, problem state), the block drives a level interrupt request toward the core. When the core takes the interrupt it pulses an accept strobe. The block then picks one cause in a fixed priority order, reports it one cycle later, and clears that cause's pending bit.

The countdown timer is controlled by a two-state machine. In `TMR_RUN` the count is nonzero. In `TMR_HELD` the count is zero. The machine moves from `TMR_RUN` to `TMR_HELD` when the next count value is zero (a tick from one, or a load of zero). It moves from `TMR_HELD` back to `TMR_RUN` when the next count value is nonzero (a direct load, or a reload to all ones). While in `TMR_HELD`, each tick flags an expiry to the pending bank.

Source indices and pending bit positions are:

| Index | Source |
|---|---|
| 0 | system reset |
| 1 | machine check |
| 2 | direct external |
| 3 | mediated external |
| 4 | countdown expiry |
| 5 | performance monitor |
| 6 | privileged doorbell |
| 7 | hypervisor doorbell |

Top module: `irq_thread_ctl`

## Requirements
- R1: After reset, the following hold: `pend_q` = 0, `tb_q` = 0, `dec_q` = all ones, `irq_req` = 0, `cause_vld` = 0 and `idx_err` = 0.
- R2: Posting a request with index n (0..7) sets `pend_q[n]` at the next edge. Clearing with index n clears it at the next edge. A post and a clear of the same index in one cycle leave the bit set.
- R3: `clr_all` zeroes all pending bits at the next edge. A post in the same cycle still sets its bit.
- R4: A post or clear with an index of 8..15 leaves every pending bit unchanged. It also drives `idx_err` high for exactly the following cycle.
- R5: Each cycle with `tick` high increments `tb_q` by one. `tb_wr` loads `tb_wdata` instead, and takes priority over `tick`.
- R6: On a tick, a nonzero `dec_q` decrements by one. A zero `dec_q` stays zero and sets `pend_q[4]` at the next edge.
- R7: With `msr_ee` high, `irq_req` is high whenever any pending bit is set. With `msr_ee` low and no hypervisor doorbell pending, `irq_req` is low.
- R8: Regardless of `msr_ee`, `irq_req` is high when `pend_q[7]` is set and either `msr_hv` is low or `msr_pr` is high.
- R9: On `ack`, the cause is chosen in this order: bit 4 first, then bit 6, then bit 7. The next cycle shows `cause_vld` = 1 with `cause` equal to the chosen index. The chosen bit is cleared at that same edge.
- R10: On `ack` with none of bits 4, 6 and 7 pending, the cycle after shows `cause_vld` = 0 (no fault), and the pending bits are unchanged.
- R11: `upd_info` reloads `dec_q` to all ones. `dec_wr` loads `dec_wdata`, and takes priority over both `upd_info` and `tick`.
- R12: When an accept clears bit 4 in the same cycle as a tick on a zero countdown, bit 4 ends up set. The accept still reports cause 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| tick | input | 1 | timer advance strobe |
| post_vld | input | 1 | post request strobe |
| post_idx | input | 4 | source index to post |
| clr_vld | input | 1 | clear request strobe |
| clr_idx | input | 4 | source index to clear |
| clr_all | input | 1 | clear every pending bit |
| msr_ee | input | 1 | external interrupt enable |
| msr_hv | input | 1 | thread in hypervisor state |
| msr_pr | input | 1 | thread in problem state |
| ack | input | 1 | core accepts an interrupt |
| upd_info | input | 1 | reload countdown to all ones |
| tb_wr | input | 1 | timebase load strobe |
| tb_wdata | input | 64 | timebase load value |
| dec_wr | input | 1 | countdown load strobe |
| dec_wdata | input | 64 | countdown load value |
| tb_q | output | 64 | timebase value |
| dec_q | output | 64 | countdown value |
| pend_q | output | 8 | pending bits |
| irq_req | output | 1 | interrupt request to the core |
| cause_vld | output | 1 | a cause was taken on the last accept |
| cause | output | 3 | index of the taken cause |
| idx_err | output | 1 | last request had a bad index |

## Verification
Two functions can fall in the same cycle. The first is the accept path, which clears the chosen countdown-expiry bit. The second is the countdown path, which sets that same bit when a tick lands on a zero count. The bench provokes this by letting the countdown reach zero, letting it raise bit 4, and then pulsing `ack` and `tick` together. The report must show cause 4 while bit 4 reads back as still set. A following accept without a tick must then clear it. Post and clear of one index in one cycle, and `clr_all` together with a post, are also provoked and judged from the pending bits seen on the next cycle.

// File: rtl/irq_thread_pkg.sv
package irq_thread_pkg;
    localparam int unsigned SRC_N   = 8;
    localparam int unsigned SRC_SEL = $clog2(SRC_N);

    typedef enum logic [SRC_SEL-1:0] {
        SRC_SYSRST  = 3'd0,
        SRC_MCHK    = 3'd1,
        SRC_EXT_DIR = 3'd2,
        SRC_EXT_MED = 3'd3,
        SRC_DECR    = 3'd4,
        SRC_PERF    = 3'd5,
        SRC_DB_PRIV = 3'd6,
        SRC_DB_HYP  = 3'd7
    } src_e;

    typedef enum logic {
        TMR_RUN  = 1'b0,
        TMR_HELD = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_vld,
    input  logic [IDX_W-1:0]   post_idx,
    input  logic               clr_vld,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic               clr_all,
    input  logic [NUM_SRC-1:0] ack_mask,
    input  logic [NUM_SRC-1:0] set_mask,
    output logic [NUM_SRC-1:0] pend_q,
    output logic               idx_err_q
);
    localparam int unsigned SEL_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] post_m;
    logic [NUM_SRC-1:0] clr_m;
    logic [NUM_SRC-1:0] pend_d;
    logic               bad_req;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
        assign post_m[g] = post_vld && (post_idx == IDX_W'(g));
        assign clr_m[g]  = clr_vld  && (clr_idx  == IDX_W'(g));
    end

    assign bad_req = (post_vld && (post_idx >= IDX_W'(NUM_SRC))) ||
                     (clr_vld  && (clr_idx  >= IDX_W'(NUM_SRC)));

    always_comb begin
        pend_d = clr_all ? '0 : pend_q;
        pend_d = pend_d & ~clr_m & ~ack_mask;
        pend_d = pend_d | post_m | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            idx_err_q <= 1'b0;
        end else begin
            pend_q    <= pend_d;
            idx_err_q <= bad_req;
        end
    end

    // R4: a bad index touches no bit and flags an error
    a_r4_bad_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && post_idx >= IDX_W'(NUM_SRC) && !clr_vld && !clr_all &&
         ack_mask == '0 && set_mask == '0)
        |=> (pend_q == $past(pend_q) && idx_err_q));

    // R2: a good post always lands
    a_r2_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && post_idx < IDX_W'(NUM_SRC))
        |=> pend_q[$past(post_idx[SEL_W-1:0])]);

    // R3: clear-all with nothing else leaves nothing pending
    a_r3_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !post_vld && set_mask == '0) |=> pend_q == '0);
endmodule

// File: rtl/irq_timer_unit.sv
module irq_timer_unit #(
    parameter int unsigned TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          upd_info,
    input  logic          tb_wr,
    input  logic [TW-1:0] tb_wdata,
    input  logic          dec_wr,
    input  logic [TW-1:0] dec_wdata,
    output logic [TW-1:0] tb_q,
    output logic [TW-1:0] dec_q,
    output logic          uflow
);
    import irq_thread_pkg::*;

    localparam logic [TW-1:0] DEC_RELOAD = '1;

    tmr_state_e    state_q, state_d;
    logic [TW-1:0] tb_d, dec_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_RUN;
            tb_q    <= '0;
            dec_q   <= DEC_RELOAD;
        end else begin
            state_q <= state_d;
            tb_q    <= tb_d;
            dec_q   <= dec_d;
        end
    end

    always_comb begin
        tb_d  = tb_q;
        dec_d = dec_q;
        uflow = 1'b0;
        if (tb_wr)     tb_d = tb_wdata;
        else if (tick) tb_d = tb_q + TW'(1);
        unique case (state_q)
            TMR_RUN: begin
                if (tick) dec_d = dec_q - TW'(1);
            end
            TMR_HELD: begin
                uflow = tick;
            end
            default: ;
        endcase
        if (dec_wr)        dec_d = dec_wdata;
        else if (upd_info) dec_d = DEC_RELOAD;
        state_d = (dec_d == '0) ? TMR_HELD : TMR_RUN;
    end

    // R5: timebase steps by one on a bare tick
    a_r5_tb_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !tb_wr) |=> tb_q == $past(tb_q) + TW'(1));

    // R6: a zero countdown does not wrap
    a_r6_dec_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dec_wr && !upd_info && dec_q == '0) |=> dec_q == '0);

    // R11: reload strobe restores all ones
    a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_info && !dec_wr) |=> dec_q == DEC_RELOAD);
endmodule

// File: rtl/irq_cause_sel.sv
module irq_cause_sel #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0]         pend,
    input  logic                       msr_ee,
    input  logic                       msr_hv,
    input  logic                       msr_pr,
    output logic                       irq_req,
    output logic                       hit,
    output logic [$clog2(NUM_SRC)-1:0] sel,
    output logic [NUM_SRC-1:0]         sel_mask
);
    import irq_thread_pkg::*;

    localparam int unsigned SEL_W = $clog2(NUM_SRC);

    assign irq_req = (msr_ee && (|pend)) ||
                     (pend[SRC_DB_HYP] && (!msr_hv || msr_pr));

    always_comb begin
        hit      = 1'b1;
        sel      = '0;
        sel_mask = '0;
        if (pend[SRC_DECR])         sel = SEL_W'(SRC_DECR);
        else if (pend[SRC_DB_PRIV]) sel = SEL_W'(SRC_DB_PRIV);
        else if (pend[SRC_DB_HYP])  sel = SEL_W'(SRC_DB_HYP);
        else                        hit = 1'b0;
        if (hit) sel_mask[sel] = 1'b1;
    end
endmodule

// File: rtl/irq_thread_ctl.sv
module irq_thread_ctl #(
    parameter int unsigned TW        = 64,
    parameter int unsigned REQ_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 post_vld,
    input  logic [REQ_IDX_W-1:0] post_idx,
    input  logic                 clr_vld,
    input  logic [REQ_IDX_W-1:0] clr_idx,
    input  logic                 clr_all,
    input  logic                 msr_ee,
    input  logic                 msr_hv,
    input  logic                 msr_pr,
    input  logic                 ack,
    input  logic                 upd_info,
    input  logic                 tb_wr,
    input  logic [TW-1:0]        tb_wdata,
    input  logic                 dec_wr,
    input  logic [TW-1:0]        dec_wdata,
    output logic [TW-1:0]        tb_q,
    output logic [TW-1:0]        dec_q,
    output logic [7:0]           pend_q,
    output logic                 irq_req,
    output logic                 cause_vld,
    output logic [2:0]           cause,
    output logic                 idx_err
);
    import irq_thread_pkg::*;

    localparam int unsigned NSRC  = SRC_N;
    localparam int unsigned SEL_W = SRC_SEL;

    logic             uflow;
    logic             hit;
    logic [SEL_W-1:0] sel;
    logic [NSRC-1:0]  sel_mask, ack_mask, set_mask;

    assign ack_mask = ack ? sel_mask : '0;

    always_comb begin
        set_mask           = '0;
        set_mask[SRC_DECR] = uflow;
    end

    irq_timer_unit #(.TW(TW)) u_tmr (
        .clk, .rst_n, .tick, .upd_info, .tb_wr, .tb_wdata,
        .dec_wr, .dec_wdata, .tb_q, .dec_q, .uflow
    );

    irq_pend_bank #(.NUM_SRC(NSRC), .IDX_W(REQ_IDX_W)) u_bank (
        .clk, .rst_n, .post_vld, .post_idx, .clr_vld, .clr_idx, .clr_all,
        .ack_mask, .set_mask, .pend_q, .idx_err_q(idx_err)
    );

    irq_cause_sel #(.NUM_SRC(NSRC)) u_sel (
        .pend(pend_q), .msr_ee, .msr_hv, .msr_pr,
        .irq_req, .hit, .sel, .sel_mask
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_vld <= 1'b0;
            cause     <= '0;
        end else begin
            cause_vld <= ack && hit;
            cause     <= (ack && hit) ? sel : '0;
        end
    end

    // R8: hypervisor doorbell bypasses the enable
    a_r8_hyp_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[SRC_DB_HYP] && (!msr_hv || msr_pr)) |-> irq_req);

    // R7: with enable low and no doorbell path, no request
    a_r7_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!msr_ee && !pend_q[SRC_DB_HYP]) |-> !irq_req);

    // R9: an accept with a candidate reports it
    a_r9_ack_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pend_q[SRC_DECR]) |=> (cause_vld && cause == 3'(SRC_DECR)));

    // R10: an accept with no candidate reports no fault
    a_r10_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !pend_q[SRC_DECR] && !pend_q[SRC_DB_PRIV] && !pend_q[SRC_DB_HYP])
        |=> !cause_vld);
endmodule

// File: tb/irq_thread_ctl_tb.sv
module irq_thread_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 0, post_vld = 0, clr_vld = 0, clr_all = 0;
    logic [3:0]  post_idx = 0, clr_idx = 0;
    logic        msr_ee = 0, msr_hv = 0, msr_pr = 0;
    logic        ack = 0, upd_info = 0, tb_wr = 0, dec_wr = 0;
    logic [63:0] tb_wdata = 0, dec_wdata = 0;
    logic [63:0] tb_q, dec_q;
    logic [7:0]  pend_q;
    logic        irq_req, cause_vld, idx_err;
    logic [2:0]  cause;

    localparam logic [63:0] ONES = '1;
    localparam int S_PEND = 0, S_TB = 1, S_DEC = 2, S_IRQ = 3,
                   S_CVLD = 4, S_CAUSE = 5, S_ERR = 6;

    typedef struct {
        int          due;
        int          sig;
        logic [63:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    irq_thread_ctl u_dut (
        .clk, .rst_n, .tick, .post_vld, .post_idx, .clr_vld, .clr_idx,
        .clr_all, .msr_ee, .msr_hv, .msr_pr, .ack, .upd_info, .tb_wr,
        .tb_wdata, .dec_wr, .dec_wdata, .tb_q, .dec_q, .pend_q, .irq_req,
        .cause_vld, .cause, .idx_err
    );

    function automatic logic [63:0] sample(int s);
        case (s)
            S_PEND:  return {56'd0, pend_q};
            S_TB:    return tb_q;
            S_DEC:   return dec_q;
            S_IRQ:   return {63'd0, irq_req};
            S_CVLD:  return {63'd0, cause_vld};
            S_CAUSE: return {61'd0, cause};
            default: return {63'd0, idx_err};
        endcase
    endfunction

    task automatic exp_push(int d, int sig, logic [63:0] v, string tag);
        q.push_back('{cyc + d, sig, v, tag});
    endtask

    task automatic nxt();
        @(posedge clk);
        #2;
        tick = 0; post_vld = 0; clr_vld = 0; clr_all = 0;
        ack = 0; upd_info = 0; tb_wr = 0; dec_wr = 0;
    endtask

    // monitor: pops due items and compares
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due <= cyc) begin
                    logic [63:0] act;
                    act = sample(q[i].sig);
                    checks++;
                    if (act !== q[i].val) begin
                        errors++;
                        $display("FAIL %s: signal %0d actual %h expected %h",
                                 q[i].tag, q[i].sig, act, q[i].val);
                    end
                    q.delete(i);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        exp_push(1, S_PEND, 0, "R1"); exp_push(1, S_TB, 0, "R1");
        exp_push(1, S_DEC, ONES, "R1"); exp_push(1, S_IRQ, 0, "R1");
        exp_push(1, S_CVLD, 0, "R1"); exp_push(1, S_ERR, 0, "R1");

        // R2 post / clear / collision
        nxt(); post_vld = 1; post_idx = 2; exp_push(1, S_PEND, 64'h04, "R2");
        nxt(); post_vld = 1; post_idx = 5; clr_vld = 1; clr_idx = 2;
        exp_push(1, S_PEND, 64'h20, "R2");
        nxt(); post_vld = 1; post_idx = 3; clr_vld = 1; clr_idx = 3;
        exp_push(1, S_PEND, 64'h28, "R2");

        // R3 clear all, with and without a post
        nxt(); clr_all = 1; post_vld = 1; post_idx = 1; exp_push(1, S_PEND, 64'h02, "R3");
        nxt(); clr_all = 1; exp_push(1, S_PEND, 0, "R3");

        // R4 bad indices
        nxt(); post_vld = 1; post_idx = 9;
        exp_push(1, S_PEND, 0, "R4"); exp_push(1, S_ERR, 1, "R4");
        nxt(); post_vld = 1; post_idx = 0; exp_push(1, S_ERR, 0, "R4");
        nxt(); clr_vld = 1; clr_idx = 12;
        exp_push(1, S_PEND, 64'h01, "R4"); exp_push(1, S_ERR, 1, "R4");
        nxt(); clr_all = 1;

        // R7 enable gating
        nxt(); post_vld = 1; post_idx = 1;
        nxt(); exp_push(1, S_IRQ, 0, "R7");
        nxt(); msr_ee = 1; exp_push(1, S_IRQ, 1, "R7");
        nxt(); msr_ee = 0; clr_all = 1;

        // R8 hypervisor doorbell bypass
        nxt(); post_vld = 1; post_idx = 7; msr_hv = 1; msr_pr = 0;
        nxt(); exp_push(1, S_IRQ, 0, "R8");
        nxt(); msr_pr = 1; exp_push(1, S_IRQ, 1, "R8");
        nxt(); msr_hv = 0; msr_pr = 0; exp_push(1, S_IRQ, 1, "R8");
        nxt(); msr_hv = 1; msr_ee = 1; exp_push(1, S_IRQ, 1, "R7");
        nxt(); msr_ee = 0; clr_all = 1;

        // R9 priority order of accepts
        nxt(); post_vld = 1; post_idx = 7;
        nxt(); post_vld = 1; post_idx = 4;
        nxt(); post_vld = 1; post_idx = 6;
        nxt(); ack = 1;
        exp_push(1, S_CVLD, 1, "R9"); exp_push(1, S_CAUSE, 4, "R9");
        exp_push(1, S_PEND, 64'hC0, "R9");
        nxt(); ack = 1;
        exp_push(1, S_CAUSE, 6, "R9"); exp_push(1, S_PEND, 64'h80, "R9");
        nxt(); ack = 1;
        exp_push(1, S_CAUSE, 7, "R9"); exp_push(1, S_PEND, 0, "R9");

        // R10 no candidate at accept
        nxt(); post_vld = 1; post_idx = 0;
        nxt(); ack = 1;
        exp_push(1, S_CVLD, 0, "R10"); exp_push(1, S_PEND, 64'h01, "R10");

        // R5 timebase
        nxt(); tb_wr = 1; tb_wdata = 64'd100; exp_push(1, S_TB, 64'd100, "R5");
        nxt(); tick = 1; exp_push(1, S_TB, 64'd101, "R5");
        nxt(); tick = 1; tb_wr = 1; tb_wdata = 64'd5; exp_push(1, S_TB, 64'd5, "R5");

        // R11 countdown loads
        nxt(); dec_wr = 1; dec_wdata = 64'd3; exp_push(1, S_DEC, 64'd3, "R11");
        nxt(); upd_info = 1; exp_push(1, S_DEC, ONES, "R11");
        nxt(); dec_wr = 1; dec_wdata = 64'd2; upd_info = 1; tick = 1;
        exp_push(1, S_DEC, 64'd2, "R11");

        // R6 countdown to zero and expiry
        nxt(); clr_all = 1;
        nxt(); tick = 1; exp_push(1, S_DEC, 64'd1, "R6");
        nxt(); tick = 1; exp_push(1, S_DEC, 0, "R6"); exp_push(1, S_PEND, 0, "R6");
        nxt(); tick = 1; exp_push(1, S_DEC, 0, "R6"); exp_push(1, S_PEND, 64'h10, "R6");

        // R12 accept and expiry on bit 4 in one cycle
        nxt(); ack = 1; tick = 1;
        exp_push(1, S_CVLD, 1, "R12"); exp_push(1, S_CAUSE, 4, "R12");
        exp_push(1, S_PEND, 64'h10, "R12");
        nxt(); ack = 1;
        exp_push(1, S_CAUSE, 4, "R12"); exp_push(1, S_PEND, 0, "R12");

        nxt();
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule